// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

This block is a five-stage twisted-ring counter that divides its clock by any whole number from 2 to 10. The stages shift together on the rising clock edge. The value that enters the first stage comes from one or two of the stage outputs, and the ratio-select input chooses which ones. The select is decoded inside the block, so no external feedback wiring is needed. Each stage drives an active-low output. The true output of the first stage is also brought out as the divided clock.

Two asynchronous controls set the state between clock edges. Reset drives every active-low output to 1, and reset wins when both controls are high. Preset loads the five jam bits, so each active-low output shows the inverse of its jam bit. A preset can leave the ring holding a pattern that is not in the counting sequence. Anti-lock gating detects such a pattern and shifts zeros in until the ring is back in the sequence.

Top module: `jdiv_counter`

## Requirements
- R1: While `rst` is 1, all five bits of `stage_qn` are 1. This takes effect at once, without waiting for a clock edge.
- R2: When `rst` and `preset_en` are both 1, `stage_qn` is all ones and the jam bits are ignored.
- R3: While `preset_en` is 1 and `rst` is 0, `stage_qn[i]` equals the inverse of `jam[i]`. This takes effect at once, without waiting for a clock edge.
- R4: On each rising clock edge with both controls low, stage i+1 takes the old value of stage i, and stage 0 takes the ring data bit. Bit i of `stage_qn` belongs to stage i+1 when stages are counted 1 to 5.
- R5: For an even N, the data bit is `stage_qn` of stage N/2. From reset with N=10, the sequence gives `stage_qn`=5'h03 after 7 clocks. With N=6 it gives 5'h07 after 6 clocks.
- R6: For an odd N, the data bit is the AND of `stage_qn` of stages (N-1)/2 and (N+1)/2. From reset with N=7, `stage_qn` is 5'h11 after 4 clocks and 5'h1E after 8 clocks.
- R7: `div_out` equals the true (non-inverted) output of stage 1. Once the counter is counting, `div_out` has period N with one rising edge per period. It is high for N/2 clocks when N is even and for (N-1)/2 clocks when N is odd.
- R8: From any of the 32 preset patterns, after at most 5 clocks the 5-bit state repeats with a period of exactly N.
- R9: The used stages are stages 1 to ceil(N/2). If they hold a pattern with more than one 0/1 boundary, or hold all ones when N is odd, the data bit is forced to 0. Example: N=6 with jam 5'h0A gives `stage_qn`=5'h0B after one clock.
- R10: A change of `div_sel` takes effect at the next rising edge, with no reset needed.
- R11: `div_sel` holds N in binary. Values 0 and 1 act as 2, and values 11 to 15 act as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| preset_en | input | 1 | Asynchronous jam load, active high |
| jam | input | 5 | Jam data, bit i for stage i+1 |
| div_sel | input | 4 | Division ratio N |
| stage_qn | output | 5 | Active-low stage outputs |
| div_out | output | 1 | Divided clock, true output of stage 1 |

## Verification
The bench loads every one of the 32 jam patterns under every ratio from 2 to 10. For each case it checks that the state returns to itself after exactly N clocks and never sooner. Missing or wrong anti-lock gating would leave some patterns in a short parasitic loop, and the check would catch that. Fixed sequences from reset and from preset pin down the feedback taps: a tap that is off by one stage would produce wrong `stage_qn` values within a few clocks. The clamping of out-of-range select values is also checked this way. Directed tests raise reset and preset between clock edges, raise both controls together, and change `div_sel` between two edges. These catch a reset or preset that waits for the clock, a wrong priority between the two controls, and a select value that is sampled late.

// File: rtl/jdiv_pkg.sv
// Package: shared sizing for the Johnson divider.
// Assumes the number of stages is at least 2; the ratio range is 2..2*stages.
package jdiv_pkg;
    localparam int unsigned NSTAGE_DEF = 5;
    localparam int unsigned SEL_W_DEF  = 4;
    // Decoded feedback choice handed from the tap decoder to the gating.
    typedef enum logic {FB_EVEN = 1'b0, FB_ODD = 1'b1} fb_kind_e;
endpackage

// File: rtl/jdiv_tap_select.sv
// Tap decoder: clamps the ratio, works out how many stages are in use and
// forms the raw ring data bit from the active-low stage outputs.
// Assumes qn is the registered active-low ring state.
module jdiv_tap_select
    import jdiv_pkg::*;
#(
    parameter int unsigned NSTAGE = NSTAGE_DEF,
    parameter int unsigned SEL_W  = SEL_W_DEF
) (
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [NSTAGE-1:0] qn,
    output fb_kind_e          kind,
    output logic [NSTAGE-1:0] used_mask,
    output logic              fb_raw
);
    localparam logic [SEL_W-1:0] N_MIN = SEL_W'(2);
    localparam logic [SEL_W-1:0] N_MAX = SEL_W'(2 * NSTAGE);

    logic [SEL_W-1:0] n_eff;
    logic [SEL_W-1:0] used_len;
    logic             tap_hi;
    logic             tap_lo;

    // Clamp the requested ratio to the supported range.
    always_comb begin
        if (div_sel < N_MIN)      n_eff = N_MIN;
        else if (div_sel > N_MAX) n_eff = N_MAX;
        else                      n_eff = div_sel;
    end

    // Stages in use: N/2 for even N, (N+1)/2 for odd N.
    always_comb begin
        used_len = (n_eff + SEL_W'(1)) >> 1;
        kind     = n_eff[0] ? FB_ODD : FB_EVEN;
    end

    // Per-stage mask and tap pick-off; the loop repeats for every stage.
    always_comb begin
        tap_hi    = 1'b1;
        tap_lo    = 1'b1;
        used_mask = '0;
        for (int i = 0; i < int'(NSTAGE); i++) begin
            if (SEL_W'(i) < used_len)             used_mask[i] = 1'b1;
            if (SEL_W'(i) == used_len - SEL_W'(1)) tap_hi = qn[i];
            if (SEL_W'(i) == used_len - SEL_W'(2)) tap_lo = qn[i];
        end
    end

    // Even ratio feeds back one output; odd ratio ANDs two neighbours.
    always_comb begin
        if (kind == FB_ODD) fb_raw = tap_hi & tap_lo;
        else                fb_raw = tap_hi;
    end

    // An odd ratio always has two stages to pick from.
    always_comb begin
        AST_ODD_HAS_TWO: assert (kind != FB_ODD || used_len >= SEL_W'(2)); // R6
    end
endmodule

// File: rtl/jdiv_antilock.sv
// Anti-lock gate: detects ring patterns outside the counting sequence and
// forces a 0 into the ring until the pattern is legal again.
// Assumes state is the true-polarity ring and used_mask is a low-side mask.
module jdiv_antilock
    import jdiv_pkg::*;
#(
    parameter int unsigned NSTAGE = NSTAGE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preset_en,
    input  logic [NSTAGE-1:0] state,
    input  logic [NSTAGE-1:0] used_mask,
    input  fb_kind_e          kind,
    input  logic              fb_raw,
    output logic              ring_d
);
    localparam int unsigned CNT_W = $clog2(NSTAGE + 3);

    logic [NSTAGE-2:0] boundary;
    logic              full_ones;
    logic              illegal;
    logic [CNT_W-1:0]  bad_run;

    // Mark each 0/1 boundary between neighbouring used stages.
    for (genvar g = 0; g < int'(NSTAGE) - 1; g++) begin : g_bound
        assign boundary[g] = (state[g] ^ state[g+1]) & used_mask[g+1];
    end

    // Legal patterns have at most one boundary; odd ratios also drop all-ones.
    always_comb begin
        full_ones = &(state | ~used_mask);
        illegal   = !$onehot0(boundary) || (kind == FB_ODD && full_ones);
        ring_d    = illegal ? 1'b0 : fb_raw;
    end

    // Run length of consecutive illegal samples, used only by the checks.
    always_ff @(posedge clk or posedge rst) begin
        if (rst)            bad_run <= '0;
        else if (preset_en) bad_run <= '0;
        else if (!illegal)  bad_run <= '0;
        else if (bad_run != '1) bad_run <= bad_run + CNT_W'(1);
    end

    AST_ZERO_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (illegal && !preset_en) |=> (preset_en || state[0] == 1'b0)); // R9
    AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (rst)
        bad_run <= CNT_W'(NSTAGE - 1)); // R8
endmodule

// File: rtl/jdiv_ring.sv
// Ring register: one flip-flop per stage, asynchronously cleared by reset
// and asynchronously loaded from jam by preset; otherwise shifts on clk.
// Assumes reset outranks preset; jam is held steady while preset is high.
module jdiv_ring
    import jdiv_pkg::*;
#(
    parameter int unsigned NSTAGE = NSTAGE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preset_en,
    input  logic [NSTAGE-1:0] jam,
    input  logic              ring_d,
    output logic [NSTAGE-1:0] state
);
    logic [NSTAGE-1:0] shift_in;

    // Stage 0 takes the gated data bit, the rest take their neighbour.
    assign shift_in = {state[NSTAGE-2:0], ring_d};

    for (genvar g = 0; g < int'(NSTAGE); g++) begin : g_stage
        // One stage: clear, jam load, or shift.
        always_ff @(posedge clk or posedge rst or posedge preset_en) begin
            if (rst)            state[g] <= 1'b0;
            else if (preset_en) state[g] <= jam[g];
            else                state[g] <= shift_in[g];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |-> state == '0); // R1
    AST_PRESET_JAM: assert property (@(posedge clk) disable iff (rst)
        (preset_en && $stable(jam)) |-> state == jam); // R3
    AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && $past(!preset_en && !rst))
            |-> state[NSTAGE-1:1] == $past(state[NSTAGE-2:0])); // R4
endmodule

// File: rtl/jdiv_counter.sv
// Top: presettable Johnson divide-by-N counter. Ties the ring, the tap
// decoder and the anti-lock gate together; outputs are active low.
// Assumes div_sel holds N in binary; reset and preset are asynchronous.
module jdiv_counter
    import jdiv_pkg::*;
#(
    parameter int unsigned NSTAGE = NSTAGE_DEF,
    parameter int unsigned SEL_W  = SEL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preset_en,
    input  logic [NSTAGE-1:0] jam,
    input  logic [SEL_W-1:0]  div_sel,
    output logic [NSTAGE-1:0] stage_qn,
    output logic              div_out
);
    logic [NSTAGE-1:0] state;
    logic [NSTAGE-1:0] used_mask;
    fb_kind_e          kind;
    logic              fb_raw;
    logic              ring_d;

    jdiv_ring #(.NSTAGE(NSTAGE)) u_ring (
        .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam),
        .ring_d(ring_d), .state(state)
    );

    jdiv_tap_select #(.NSTAGE(NSTAGE), .SEL_W(SEL_W)) u_taps (
        .div_sel(div_sel), .qn(stage_qn), .kind(kind),
        .used_mask(used_mask), .fb_raw(fb_raw)
    );

    jdiv_antilock #(.NSTAGE(NSTAGE)) u_lock (
        .clk(clk), .rst(rst), .preset_en(preset_en), .state(state),
        .used_mask(used_mask), .kind(kind), .fb_raw(fb_raw), .ring_d(ring_d)
    );

    // Outputs: inverted ring state and the first stage's true output.
    always_comb begin
        stage_qn = ~state;
        div_out  = state[0];
    end

    AST_PRIORITY_RESET: assert property (@(posedge clk)
        (rst && preset_en) |-> stage_qn == '1); // R2
endmodule

// File: tb/sim_jdiv_counter.sv
`timescale 1ns/1ps
module sim_jdiv_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       preset_en = 1'b0;
    logic [4:0] jam = '0;
    logic [3:0] div_sel = 4'd2;
    logic [4:0] stage_qn;
    logic       div_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    jdiv_counter u0 (.clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam),
                     .div_sel(div_sel), .stage_qn(stage_qn), .div_out(div_out));

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0] sel;
        logic       pre;
        logic [4:0] jam;
        logic [4:0] clks;
        logic [4:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b0, 5'h00, 5'd6, 5'h15},  // R5
        '{4'd10, 1'b0, 5'h00, 5'd7, 5'h03},  // R5
        '{4'd6,  1'b0, 5'h00, 5'd6, 5'h07},  // R5
        '{4'd4,  1'b0, 5'h00, 5'd5, 5'h06},  // R5
        '{4'd7,  1'b0, 5'h00, 5'd4, 5'h11},  // R6
        '{4'd7,  1'b0, 5'h00, 5'd8, 5'h1E},  // R6
        '{4'd3,  1'b0, 5'h00, 5'd5, 5'h0D},  // R6
        '{4'd5,  1'b0, 5'h00, 5'd5, 5'h07},  // R6
        '{4'd0,  1'b0, 5'h00, 5'd6, 5'h15},  // R11
        '{4'd15, 1'b0, 5'h00, 5'd7, 5'h03},  // R11
        '{4'd6,  1'b1, 5'h0A, 5'd1, 5'h0B},  // R9
        '{4'd6,  1'b1, 5'h0A, 5'd2, 5'h17},  // R9
        '{4'd10, 1'b1, 5'h0A, 5'd3, 5'h0F},  // R9
        '{4'd10, 1'b1, 5'h0A, 5'd4, 5'h1F},  // R9
        '{4'd9,  1'b1, 5'h1F, 5'd1, 5'h01},  // R9
        '{4'd6,  1'b1, 5'h0A, 5'd0, 5'h15}   // R3
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Start from reset or from a jam load that spans one clock edge.
    task automatic start(input logic [3:0] sel, input logic pre, input logic [4:0] j);
        @(negedge clk);
        div_sel = sel; jam = j;
        if (pre) preset_en = 1'b1; else rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0; preset_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1 check("R1 reset state", stage_qn, 5'h1F);
        check("R7 reset div_out", {4'b0, div_out}, 5'h00);

        for (int v = 0; v < NV; v++) begin
            start(VECS[v].sel, VECS[v].pre, VECS[v].jam);
            if (VECS[v].clks != 0) tick(int'(VECS[v].clks));
            check($sformatf("vector %0d", v), stage_qn, VECS[v].exp);
        end

        // R1: reset acts between edges.
        start(4'd10, 1'b0, 5'h00);
        tick(3);
        #2 rst = 1'b1;
        #1 check("R1 async reset", stage_qn, 5'h1F);
        @(negedge clk) rst = 1'b0;

        // R3: preset acts between edges.
        #2 jam = 5'h13; preset_en = 1'b1;
        #1 check("R3 async preset", stage_qn, 5'h0C);
        @(negedge clk) preset_en = 1'b0;

        // R2: reset outranks preset.
        #2 jam = 5'h13; rst = 1'b1; preset_en = 1'b1;
        #1 check("R2 priority", stage_qn, 5'h1F);
        @(negedge clk) rst = 1'b0; preset_en = 1'b0;

        // R4: shift chain, one 1 entering then moving up.
        start(4'd10, 1'b0, 5'h00);
        tick(1);
        check("R4 first shift", stage_qn, 5'h1E);

        // R10: select change lands on the next edge.
        start(4'd2, 1'b0, 5'h00);
        tick(1);
        div_sel = 4'd10;
        tick(1);
        check("R10 select change", stage_qn, 5'h1C);

        // R7: div_out period, single rise, duty.
        for (int n = 2; n <= 10; n++) begin
            logic [19:0] w;
            int ones, rises;
            start(4'(n), 1'b0, 5'h00);
            tick(5);
            w = '0;
            for (int i = 0; i < 2 * n; i++) begin
                w[i] = div_out;
                tick(1);
            end
            ones = 0; rises = 0;
            for (int i = 0; i < n; i++) begin
                if (w[i] !== w[i+n]) rises = 99;
                if (w[i]) ones++;
                if (w[i] && !w[(i + n - 1) % n]) rises++;
            end
            check($sformatf("R7 rises N=%0d", n), 5'(rises), 5'd1);
            check($sformatf("R7 high N=%0d", n), 5'(ones), 5'(n / 2 - (n % 2 == 0 ? 0 : 0)));
        end

        // R8: every jam pattern settles into an exact period of N.
        for (int n = 2; n <= 10; n++) begin
            for (int j = 0; j < 32; j++) begin
                logic [4:0] ref_q;
                int bad;
                start(4'(n), 1'b1, 5'(j));
                tick(5);
                ref_q = stage_qn;
                bad = 0;
                for (int i = 1; i < n; i++) begin
                    tick(1);
                    if (stage_qn == ref_q) bad = 1;
                end
                tick(1);
                checks++;
                if (bad != 0 || stage_qn != ref_q) begin
                    errors++;
                    $display("FAIL R8 N=%0d jam=%h actual %h expected %h early=%0d",
                             n, j, stage_qn, ref_q, bad);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule